// File: doc/BRIEF.md
# Token-Ring Shared Block Node Controller

This block is the coherence engine of one node on a ring of nodes that share a block-granular memory. Shared memory moves in 32-byte blocks. Every block has one fixed home node. The node keeps a table with one entry per block. Each entry holds four fields:
- a valid bit;
- an exclusive bit;
- a home bit;
- a slot index that locates the block's local copy.

The node serves read and write requests from its local processor. Traffic that other nodes place on the ring goes through this node, and the node acts on it.

A request that hits the table completes without using the ring. When a request needs other nodes, the controller waits for the circulating token and consumes it. It then launches a packet, which is a header followed by empty data beats when a block copy is wanted. The packet travels the whole ring. The controller recognises the packet by its source field when it comes back and removes it. It then updates the table and passes the token on.

As a foreign packet goes by, a node that holds the addressed block acts in place:
- On a read request, it writes the block into the empty beats and gives up exclusivity.
- On a combined read-invalidate, the first holder fills the beats, marks the header as filled and drops its own copy. Any later holder only drops its copy.
- On a pure invalidate, any holder drops its copy.

Top module: `ring_share_node`

## Requirements
- R1: After reset, every block whose number modulo NODES equals NODE_ID is valid and exclusive with all-zero data, every other block is invalid, the ring output carries control code 0 (idle) and no completion is signalled.
- R2: A read of a valid block raises cpu_done_o for exactly one cycle, in the cycle after the request is first presented, with the addressed 16-bit word on cpu_rdata_o, and causes no ring traffic.
- R3: A write to a valid exclusive block completes in the cycle after the request with no ring traffic, and later reads return the written word.
- R4: A read miss waits for a token (control 1) and consumes it, so that the ring output stays idle. It then sends a read header (control 2) whose data carries the node ID in bits [BLK_W+ID_W-1:BLK_W] and the block number in bits [BLK_W-1:0], followed by 16 empty beats (control 6, data 0). The returned beats become the block copy, which is valid and not exclusive.
- R5: A write to a valid non-exclusive block sends only an invalidate header (control 3). When that header returns, the block becomes exclusive and the word is written.
- R6: A write miss sends a read-invalidate header (control 4) and 16 empty beats. On return the block is filled, made valid and exclusive, and then the word is written.
- R7: A foreign read header (control 2) for a valid block is forwarded unchanged, and its following 16 beats leave as filled beats (control 7) carrying the block's words in order. The block loses exclusivity.
- R8: A foreign unfilled read-invalidate header (control 4) for a valid block leaves as a filled header (control 5), its beats carry the block, and the local copy becomes invalid.
- R9: A foreign filled read-invalidate (control 5) or invalidate (control 3) for a valid block is forwarded unchanged, and the local copy becomes invalid.
- R10: Ring items that do not concern a held block, and tokens that the node does not want, leave the node unchanged one cycle after they arrive.
- R11: The node's own packet is removed as it returns, so the ring output stays idle. The token is sent out in the same cycle as the completion pulse.
- R12: A home block that has been invalidated is refilled into its reserved slot, and a later read miss on it returns the supplied data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Local request present; held until cpu_done_o |
| cpu_write_i | input | 1 | 1 = write, 0 = read |
| cpu_block_i | input | BLK_W | Block number |
| cpu_word_i | input | BEAT_W | 16-bit word index within the block |
| cpu_wdata_i | input | 16 | Write data |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 16 | Read data, valid with cpu_done_o |
| ring_ctl_i | input | 4 | Incoming ring control code |
| ring_data_i | input | 16 | Incoming ring data |
| ring_ctl_o | output | 4 | Outgoing ring control code (registered) |
| ring_data_o | output | 16 | Outgoing ring data (registered) |

## Verification
The bench focuses on four corner cases.
- A write to a block that another node has read from. A design that forgot to clear exclusivity on supply would write locally and never send the invalidate header.
- A foreign read-invalidate that reaches a holder after an earlier node has already filled it. Refilling the beats or keeping the copy would either corrupt the packet or leave a stale sharer. Both show up at the ring output or on the next local read.
- Losing and refilling a home block. A wrong slot choice there makes later reads return another block's words.
- Returning own packets, checked against random interleavings of local hits and misses. A node that forwarded its own packet instead of removing it would leave non-idle items on the ring, and one that held the token too long would never release it.

// File: rtl/rn_pkg.sv
package rn_pkg;

  localparam int RING_DW = 16;

  typedef enum logic [3:0] {
    RC_IDLE       = 4'd0,
    RC_TOKEN      = 4'd1,
    RC_RD         = 4'd2,
    RC_INV        = 4'd3,
    RC_RDX        = 4'd4,
    RC_RDX_DONE   = 4'd5,
    RC_BEAT_EMPTY = 4'd6,
    RC_BEAT_FULL  = 4'd7
  } ring_ctl_e;

  function automatic logic is_hdr(input ring_ctl_e c);
    return (c == RC_RD) || (c == RC_INV) || (c == RC_RDX) || (c == RC_RDX_DONE);
  endfunction

  function automatic logic is_beat(input ring_ctl_e c);
    return (c == RC_BEAT_EMPTY) || (c == RC_BEAT_FULL);
  endfunction

endpackage

// File: rtl/rn_block_table.sv
module rn_block_table #(
  parameter int BLOCKS  = 16,
  parameter int NODES   = 4,
  parameter int NODE_ID = 0,
  localparam int BLK_W  = $clog2(BLOCKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] a_blk_i,
  output logic             a_valid_o,
  output logic             a_excl_o,
  output logic             a_home_o,
  output logic [BLK_W-1:0] a_loc_o,
  input  logic [BLK_W-1:0] b_blk_i,
  output logic             b_valid_o,
  output logic [BLK_W-1:0] b_loc_o,
  input  logic             fill_en_i,
  input  logic [BLK_W-1:0] fill_blk_i,
  input  logic             fill_excl_i,
  input  logic [BLK_W-1:0] fill_loc_i,
  input  logic             ring_en_i,
  input  logic             ring_inv_i,
  output logic [BLK_W-1:0] free_slot_o
);

  typedef struct packed {
    logic             valid;
    logic             excl;
    logic             home;
    logic [BLK_W-1:0] loc;
  } ent_t;

  ent_t       tbl_q [BLOCKS];
  logic [BLOCKS-1:0] used;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BLOCKS; b++) begin
        tbl_q[b].home  <= ((b % NODES) == NODE_ID);
        tbl_q[b].valid <= ((b % NODES) == NODE_ID);
        tbl_q[b].excl  <= ((b % NODES) == NODE_ID);
        tbl_q[b].loc   <= BLK_W'(b);
      end
    end else if (fill_en_i) begin
      tbl_q[fill_blk_i].valid <= 1'b1;
      tbl_q[fill_blk_i].excl  <= fill_excl_i;
      tbl_q[fill_blk_i].loc   <= fill_loc_i;
    end else if (ring_en_i) begin
      tbl_q[b_blk_i].excl <= 1'b0;
      if (ring_inv_i) tbl_q[b_blk_i].valid <= 1'b0;
    end
  end

  assign a_valid_o = tbl_q[a_blk_i].valid;
  assign a_excl_o  = tbl_q[a_blk_i].excl;
  assign a_home_o  = tbl_q[a_blk_i].home;
  assign a_loc_o   = tbl_q[a_blk_i].loc;
  assign b_valid_o = tbl_q[b_blk_i].valid;
  assign b_loc_o   = tbl_q[b_blk_i].loc;

  // home slots stay reserved even while the copy is invalid
  for (genvar s = 0; s < BLOCKS; s++) begin : g_slot
    logic [BLOCKS-1:0] hold;
    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
      assign hold[b] = (tbl_q[b].valid || tbl_q[b].home) && (tbl_q[b].loc == BLK_W'(s));
    end
    assign used[s] = |hold;

    p_slot_unique_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hold));
  end

  always_comb begin
    free_slot_o = '0;
    for (int s = BLOCKS - 1; s >= 0; s--) begin
      if (!used[s]) free_slot_o = BLK_W'(s);
    end
  end

  for (genvar b = 0; b < BLOCKS; b++) begin : g_chk
    p_excl_needs_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tbl_q[b].excl |-> tbl_q[b].valid);
  end

  p_one_writer_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_en_i && ring_en_i));

endmodule

// File: rtl/rn_line_store.sv
module rn_line_store #(
  parameter int SLOTS = 16,
  parameter int BEATS = 16,
  parameter int DW    = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [BEAT_W-1:0] wr_beat_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [SLOT_W-1:0] ra_slot_i,
  input  logic [BEAT_W-1:0] ra_beat_i,
  output logic [DW-1:0]     ra_data_o,
  input  logic [SLOT_W-1:0] rb_slot_i,
  input  logic [BEAT_W-1:0] rb_beat_i,
  output logic [DW-1:0]     rb_data_o
);

  logic [DW-1:0] mem_q [SLOTS*BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS * BEATS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[{wr_slot_i, wr_beat_i}] <= wr_data_i;
    end
  end

  assign ra_data_o = mem_q[{ra_slot_i, ra_beat_i}];
  assign rb_data_o = mem_q[{rb_slot_i, rb_beat_i}];

endmodule

// File: rtl/ring_share_node.sv
module ring_share_node
  import rn_pkg::*;
#(
  parameter int NODES       = 4,
  parameter int BLOCKS      = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int NODE_ID     = 0,
  localparam int ID_W   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int BEATS  = BLOCK_BYTES / 2,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cpu_valid_i,
  input  logic               cpu_write_i,
  input  logic [BLK_W-1:0]   cpu_block_i,
  input  logic [BEAT_W-1:0]  cpu_word_i,
  input  logic [RING_DW-1:0] cpu_wdata_i,
  output logic               cpu_done_o,
  output logic [RING_DW-1:0] cpu_rdata_o,
  input  logic [3:0]         ring_ctl_i,
  input  logic [RING_DW-1:0] ring_data_i,
  output logic [3:0]         ring_ctl_o,
  output logic [RING_DW-1:0] ring_data_o
);

  localparam int CNT_W = BEAT_W + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_TOK, S_SEND, S_WAIT_RET, S_FINISH, S_DONE
  } st_e;

  st_e               st_q;
  ring_ctl_e         op_q, op_sel;
  logic              req_wr_q;
  logic [BLK_W-1:0]  req_blk_q, blk_sel;
  logic [BEAT_W-1:0] req_word_q;
  logic [RING_DW-1:0] req_wdata_q, rdata_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rx_on_q;
  logic [BLK_W-1:0]  fill_slot_q, fin_loc;
  logic              sup_on_q;
  logic [BLK_W-1:0]  sup_slot_q;
  logic [BEAT_W-1:0] sup_cnt_q;
  ring_ctl_e         out_ctl_q, out_ctl_d;
  logic [RING_DW-1:0] out_data_q, out_data_d;

  logic a_valid, a_excl, a_home, b_valid;
  logic [BLK_W-1:0] a_loc, b_loc, free_slot;
  logic fill_en, ring_en, ring_inv;

  logic st_wr_en;
  logic [BLK_W-1:0]  st_wr_slot, ra_slot;
  logic [BEAT_W-1:0] st_wr_beat, ra_beat;
  logic [RING_DW-1:0] st_wr_data, ra_data, rb_data;

  ring_ctl_e in_ctl;
  logic in_hdr, in_beat, in_own, foreign_hit, sup_start;
  logic [BLK_W-1:0] in_blk;
  logic hit_rd, hit_wr;

  assign in_ctl  = ring_ctl_e'(ring_ctl_i);
  assign in_hdr  = is_hdr(in_ctl);
  assign in_beat = is_beat(in_ctl);
  assign in_blk  = ring_data_i[BLK_W-1:0];
  assign in_own  = in_hdr && (ring_data_i[BLK_W +: ID_W] == ID_W'(NODE_ID));

  assign blk_sel = (st_q == S_IDLE) ? cpu_block_i : req_blk_q;
  assign hit_rd  = !cpu_write_i && a_valid;
  assign hit_wr  = cpu_write_i && a_valid && a_excl;
  assign op_sel  = !req_wr_q ? RC_RD : (a_valid ? RC_INV : RC_RDX);
  assign fin_loc = (op_q == RC_INV) ? a_loc : fill_slot_q;

  assign foreign_hit = in_hdr && !in_own && b_valid;
  assign ring_en     = foreign_hit;
  assign ring_inv    = (in_ctl != RC_RD);
  assign sup_start   = foreign_hit && ((in_ctl == RC_RD) || (in_ctl == RC_RDX));
  assign fill_en     = (st_q == S_FINISH);

  rn_block_table #(.BLOCKS(BLOCKS), .NODES(NODES), .NODE_ID(NODE_ID)) i_table (
    .clk_i, .rst_ni,
    .a_blk_i     (blk_sel),
    .a_valid_o   (a_valid),
    .a_excl_o    (a_excl),
    .a_home_o    (a_home),
    .a_loc_o     (a_loc),
    .b_blk_i     (in_blk),
    .b_valid_o   (b_valid),
    .b_loc_o     (b_loc),
    .fill_en_i   (fill_en),
    .fill_blk_i  (req_blk_q),
    .fill_excl_i (req_wr_q),
    .fill_loc_i  (fin_loc),
    .ring_en_i   (ring_en),
    .ring_inv_i  (ring_inv),
    .free_slot_o (free_slot)
  );

  always_comb begin
    st_wr_en   = 1'b0;
    st_wr_slot = a_loc;
    st_wr_beat = cpu_word_i;
    st_wr_data = cpu_wdata_i;
    ra_slot    = a_loc;
    ra_beat    = (st_q == S_IDLE) ? cpu_word_i : req_word_q;
    unique case (st_q)
      S_IDLE: st_wr_en = cpu_valid_i && hit_wr;
      S_WAIT_RET: begin
        st_wr_en   = rx_on_q && in_beat;
        st_wr_slot = fill_slot_q;
        st_wr_beat = cnt_q[BEAT_W-1:0];
        st_wr_data = ring_data_i;
      end
      S_FINISH: begin
        st_wr_en   = req_wr_q;
        st_wr_slot = fin_loc;
        st_wr_beat = req_word_q;
        st_wr_data = req_wdata_q;
        ra_slot    = fin_loc;
      end
      default: ;
    endcase
  end

  rn_line_store #(.SLOTS(BLOCKS), .BEATS(BEATS), .DW(RING_DW)) i_store (
    .clk_i, .rst_ni,
    .wr_en_i   (st_wr_en),
    .wr_slot_i (st_wr_slot),
    .wr_beat_i (st_wr_beat),
    .wr_data_i (st_wr_data),
    .ra_slot_i (ra_slot),
    .ra_beat_i (ra_beat),
    .ra_data_o (ra_data),
    .rb_slot_i (sup_slot_q),
    .rb_beat_i (sup_cnt_q),
    .rb_data_o (rb_data)
  );

  // ring output path: own traffic overrides, otherwise forward with in-place edits
  always_comb begin
    out_ctl_d  = in_ctl;
    out_data_d = ring_data_i;
    if (st_q == S_SEND) begin
      if (cnt_q == '0) begin
        out_ctl_d  = op_q;
        out_data_d = RING_DW'({ID_W'(NODE_ID), req_blk_q});
      end else begin
        out_ctl_d  = RC_BEAT_EMPTY;
        out_data_d = '0;
      end
    end else if (st_q == S_FINISH) begin
      out_ctl_d  = RC_TOKEN;
      out_data_d = '0;
    end else if ((st_q == S_WAIT_TOK) && (in_ctl == RC_TOKEN)) begin
      out_ctl_d  = RC_IDLE;
      out_data_d = '0;
    end else if ((st_q == S_WAIT_RET) && (in_own || (rx_on_q && in_beat))) begin
      out_ctl_d  = RC_IDLE;
      out_data_d = '0;
    end else if (foreign_hit && (in_ctl == RC_RDX)) begin
      out_ctl_d = RC_RDX_DONE;
    end else if (sup_on_q && in_beat) begin
      out_ctl_d  = RC_BEAT_FULL;
      out_data_d = rb_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_ctl_q  <= RC_IDLE;
      out_data_q <= '0;
      sup_on_q   <= 1'b0;
      sup_slot_q <= '0;
      sup_cnt_q  <= '0;
    end else begin
      out_ctl_q  <= out_ctl_d;
      out_data_q <= out_data_d;
      if (sup_start) begin
        sup_on_q   <= 1'b1;
        sup_slot_q <= b_loc;
        sup_cnt_q  <= '0;
      end else if (sup_on_q && in_beat) begin
        sup_cnt_q <= sup_cnt_q + 1'b1;
        if (sup_cnt_q == BEAT_W'(BEATS - 1)) sup_on_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      op_q        <= RC_RD;
      req_wr_q    <= 1'b0;
      req_blk_q   <= '0;
      req_word_q  <= '0;
      req_wdata_q <= '0;
      rdata_q     <= '0;
      cnt_q       <= '0;
      rx_on_q     <= 1'b0;
      fill_slot_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (cpu_valid_i) begin
          req_wr_q    <= cpu_write_i;
          req_blk_q   <= cpu_block_i;
          req_word_q  <= cpu_word_i;
          req_wdata_q <= cpu_wdata_i;
          if (hit_rd) begin
            rdata_q <= ra_data;
            st_q    <= S_DONE;
          end else if (hit_wr) begin
            st_q <= S_DONE;
          end else begin
            st_q <= S_WAIT_TOK;
          end
        end
        S_WAIT_TOK: if (in_ctl == RC_TOKEN) begin
          op_q  <= op_sel;
          cnt_q <= '0;
          st_q  <= S_SEND;
        end
        S_SEND: begin
          if (((op_q == RC_INV) && (cnt_q == '0)) || (cnt_q == CNT_W'(BEATS))) begin
            cnt_q <= '0;
            st_q  <= S_WAIT_RET;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_WAIT_RET: begin
          if (in_own) begin
            if (in_ctl == RC_INV) begin
              st_q <= S_FINISH;
            end else begin
              rx_on_q     <= 1'b1;
              cnt_q       <= '0;
              fill_slot_q <= a_home ? a_loc : free_slot;
            end
          end else if (rx_on_q && in_beat) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(BEATS - 1)) begin
              rx_on_q <= 1'b0;
              st_q    <= S_FINISH;
            end
          end
        end
        S_FINISH: begin
          rdata_q <= ra_data;
          st_q    <= S_DONE;
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_done_o  = (st_q == S_DONE);
  assign cpu_rdata_o = rdata_q;
  assign ring_ctl_o  = out_ctl_q;
  assign ring_data_o = out_data_q;

  p_hit_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && cpu_valid_i && hit_rd) |=> cpu_done_o);

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);

  p_hit_wr_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && cpu_valid_i && hit_wr) |=> (cpu_done_o && st_q != S_SEND));

  p_header_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SEND && cnt_q == '0) |=>
      (ring_ctl_o == RC_RD || ring_ctl_o == RC_INV || ring_ctl_o == RC_RDX));

  p_supply_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_on_q && in_beat && st_q == S_IDLE) |=> (ring_ctl_o == RC_BEAT_FULL));

  p_own_removed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT_RET && in_own) |=> (ring_ctl_o == RC_IDLE));

  p_token_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_FINISH) |=> (ring_ctl_o == RC_TOKEN && cpu_done_o));

endmodule

// File: tb/test_ring_share_node.sv
`timescale 1ns/1ps
module test_ring_share_node;
  import rn_pkg::*;

  localparam int NODES = 4, BLOCKS = 16, NID = 1, BEATS = 16, FOREIGN = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0;
  logic [3:0] cpu_block = '0, cpu_word = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_done;
  logic [15:0] cpu_rdata;
  logic [3:0] rin_ctl = '0;
  logic [15:0] rin_data = '0;
  logic [3:0] rout_ctl;
  logic [15:0] rout_data;

  int n_chk = 0, n_fail = 0;
  logic        m_valid [BLOCKS];
  logic        m_excl  [BLOCKS];
  logic [15:0] m_data  [BLOCKS][BEATS];

  always #2 clk = ~clk;

  ring_share_node #(.NODES(NODES), .BLOCKS(BLOCKS), .BLOCK_BYTES(32), .NODE_ID(NID)) i_ring_share_node (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write), .cpu_block_i(cpu_block),
    .cpu_word_i(cpu_word), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .ring_ctl_i(rin_ctl), .ring_data_i(rin_data),
    .ring_ctl_o(rout_ctl), .ring_data_o(rout_data));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hdr(input int src, input int blk);
    return 16'((src << 4) | blk);
  endfunction

  task automatic cpu_op(input bit wr, input int blk, input int w, input logic [15:0] wd);
    int exp_op;
    logic [15:0] fill [BEATS];
    bit got_tok, got_done, bad;
    logic [15:0] rd;
    string rq;
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_block = 4'(blk); cpu_word = 4'(w); cpu_wdata = wd;
    if ((!wr && m_valid[blk]) || (wr && m_valid[blk] && m_excl[blk])) begin
      rq = wr ? "R3" : "R2";
      @(negedge clk);
      chk(cpu_done == 1'b1, rq, "hit done", cpu_done, 1);
      chk(rout_ctl == 4'd0, rq, "hit ring quiet", rout_ctl, 0);
      if (!wr) chk(cpu_rdata == m_data[blk][w], rq, "hit rdata", cpu_rdata, m_data[blk][w]);
      else m_data[blk][w] = wd;
      cpu_valid = 0;
      return;
    end
    exp_op = !wr ? 2 : (m_valid[blk] ? 3 : 4);
    rq = (exp_op == 2) ? "R4" : (exp_op == 3) ? "R5" : "R6";
    @(negedge clk);
    chk(cpu_done == 0 && rout_ctl == 4'd0, rq, "miss waits", cpu_done, 0);
    rin_ctl = 4'd1;
    @(negedge clk);
    rin_ctl = 4'd0;
    chk(rout_ctl == 4'd0, "R4", "token consumed", rout_ctl, 0);
    @(negedge clk);
    chk(rout_ctl == 4'(exp_op) && rout_data == hdr(NID, blk), rq, "header", {rout_ctl, rout_data}, {4'(exp_op), hdr(NID, blk)});
    if (exp_op != 3) begin
      bad = 0;
      for (int i = 0; i < BEATS; i++) begin
        @(negedge clk);
        if (rout_ctl != 4'd6 || rout_data != 16'd0) bad = 1;
      end
      chk(!bad, rq, "empty beats", bad, 0);
    end
    for (int i = 0; i < BEATS; i++) fill[i] = 16'($urandom);
    @(negedge clk);
    rin_ctl = 4'(exp_op); rin_data = hdr(NID, blk);
    bad = 0;
    if (exp_op != 3) begin
      for (int i = 0; i < BEATS; i++) begin
        @(negedge clk);
        if (rout_ctl != 4'd0) bad = 1;
        rin_ctl = 4'd7; rin_data = fill[i];
      end
    end
    @(negedge clk);
    if (rout_ctl != 4'd0) bad = 1;
    rin_ctl = 4'd0; rin_data = '0;
    chk(!bad, "R11", "own packet removed", bad, 0);
    got_tok = 0; got_done = 0; rd = '0;
    for (int i = 0; i < 8 && !(got_tok && got_done); i++) begin
      @(negedge clk);
      if (rout_ctl == 4'd1) got_tok = 1;
      if (cpu_done) begin got_done = 1; rd = cpu_rdata; end
    end
    chk(got_tok && got_done, "R11", "token and done", {got_tok, got_done}, 3);
    cpu_valid = 0;
    if (exp_op == 3) begin
      m_excl[blk] = 1; m_data[blk][w] = wd;
    end else begin
      for (int i = 0; i < BEATS; i++) m_data[blk][i] = fill[i];
      m_valid[blk] = 1; m_excl[blk] = wr;
      if (wr) m_data[blk][w] = wd;
      else chk(rd == fill[w], rq, "miss rdata", rd, fill[w]);
    end
  endtask

  task automatic foreign(input int ctl, input int blk);
    logic [3:0]  ic [BEATS+1], ec [BEATS+1];
    logic [15:0] id [BEATS+1], ed [BEATS+1];
    int len;
    bit bad;
    string rq;
    len = (ctl == 3 || ctl == 1) ? 1 : BEATS + 1;
    ic[0] = 4'(ctl); id[0] = (ctl == 1) ? 16'd0 : hdr(FOREIGN, blk);
    for (int i = 1; i < len; i++) begin
      ic[i] = (ctl == 5) ? 4'd7 : 4'd6;
      id[i] = (ctl == 5) ? 16'($urandom) : 16'd0;
    end
    for (int i = 0; i < len; i++) begin ec[i] = ic[i]; ed[i] = id[i]; end
    rq = "R10";
    if (ctl != 1 && m_valid[blk]) begin
      if (ctl == 2 || ctl == 4) begin
        if (ctl == 4) ec[0] = 4'd5;
        for (int i = 1; i < len; i++) begin ec[i] = 4'd7; ed[i] = m_data[blk][i-1]; end
      end
      rq = (ctl == 2) ? "R7" : (ctl == 4) ? "R8" : "R9";
      m_excl[blk] = 0;
      if (ctl != 2) m_valid[blk] = 0;
    end
    bad = 0;
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      if (i > 0 && (rout_ctl != ec[i-1] || rout_data != ed[i-1])) bad = 1;
      if (i < len) begin rin_ctl = ic[i]; rin_data = id[i]; end
      else begin rin_ctl = 4'd0; rin_data = '0; end
    end
    chk(!bad, rq, $sformatf("foreign ctl %0d blk %0d", ctl, blk), bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0c11;
    void'($urandom(seed));
    for (int b = 0; b < BLOCKS; b++) begin
      m_valid[b] = ((b % NODES) == NID);
      m_excl[b]  = ((b % NODES) == NID);
      for (int i = 0; i < BEATS; i++) m_data[b][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rout_ctl == 4'd0 && cpu_done == 0, "R1", "reset outputs", {rout_ctl, 3'b0, cpu_done}, 0);
    cpu_op(0, 5, 3, 0);                 // R1 home block reads as zero
    cpu_op(1, 5, 3, 16'hbeef);          // R3
    cpu_op(0, 5, 3, 0);
    cpu_op(0, 2, 7, 0);                 // R4
    cpu_op(1, 2, 0, 16'h1234);          // R5
    cpu_op(0, 2, 0, 0);
    cpu_op(1, 6, 9, 16'h0a0a);          // R6
    foreign(2, 6);                      // R7 supply and drop exclusivity
    cpu_op(1, 6, 1, 16'h5151);          // R7 write now needs invalidate
    foreign(4, 2);                      // R8
    foreign(4, 2);                      // R10 no longer held
    cpu_op(0, 2, 4, 0);
    foreign(3, 5);                      // R9
    foreign(5, 6);                      // R9
    foreign(2, 7);                      // R10
    foreign(1, 0);                      // R10 token passes
    cpu_op(0, 5, 3, 0);                 // R12 home refill
    cpu_op(0, 5, 8, 0);
    for (int n = 0; n < 80; n++) begin
      int k, blk;
      k = $urandom_range(0, 5);
      blk = $urandom_range(0, BLOCKS - 1);
      case (k)
        0, 1: cpu_op(0, blk, $urandom_range(0, 15), 0);
        2, 3: cpu_op(1, blk, $urandom_range(0, 15), 16'($urandom));
        4: foreign(2, blk);
        default: foreign($urandom_range(3, 5), blk);
      endcase
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule